// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Test Injection

This block gathers fifteen interrupt levels (1 to 15) into a pending register and holds a mask beside it. It presents the highest pending level that is not masked to the processor as a 4-bit request level, where 0 means no request. An acknowledge carrying a level removes that level from the pending set. Peripheral sources arrive as single-cycle pulses. A receiver overrun pulse from either of two serial channels is routed onto level 7.

For test, a force register can be loaded while a test-mode bit is set. In test mode the force bits join the pending bits as request sources. An acknowledge then removes the force bit of the serviced level when that bit is set, and the pending bit otherwise. Writes that set bits a register cannot hold raise a one-cycle register error pulse.

Registers are reached through a 2-bit select shared by the write and read sides: 0 is the mask, 1 is clear on write and pending on read, 2 is force, and 3 is test control.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending, mask, force and test registers all read zero, the request level is 0 and the error output is low.
- R2: The request level is the number of the highest set bit of the active set, where the active set is (pending OR force-when-test-mode) AND NOT mask, over bits 15:1. The level is 0 when the active set is empty.
- R3: A mask write (select 0) keeps only data bits 14:1, so level 15 can never be masked. The mask reads back zero-extended through select 0.
- R4: A mask write with any of data bits 31:15 or bit 0 set drives the error output high for exactly the cycle after the write. Legal writes leave it low.
- R5: A write to select 1 clears every pending bit whose data bit is 1. The same write raises the error output in the next cycle if any of data bits 31:16 or bit 0 is set, and it still clears the legal bits.
- R6: A write to the force register (select 2) takes effect only while the test bit (bit 19 of the select-3 register) is set. It then keeps bits 15:1. At other times the force register keeps its contents.
- R7: Force bits contribute to the request level only while the test bit is set.
- R8: An acknowledge of level L clears force bit L when test mode is on and force bit L is set. Otherwise it clears pending bit L.
- R9: A receiver overrun pulse on either serial channel sets pending level 7.
- R10: A source pulse sets its pending bit even when a clear write or an acknowledge for the same bit arrives in the same cycle.
- R11: Source bit 0 is ignored, and bit 0 of pending, mask and force always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 16 | Per-level source pulses, bit n for level n (bit 0 ignored) |
| ovr_a | input | 1 | Receiver overrun pulse, serial channel A |
| ovr_b | input | 1 | Receiver overrun pulse, serial channel B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 clear, 2 force, 3 test |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 mask, 1 pending, 2 force, 3 test |
| rd_data | output | 32 | Read data for rd_sel (combinational) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest active level, 0 when none |
| par_err | output | 1 | Register error pulse, one cycle after an illegal write |

## Verification
Every state change (pending, mask, force, test) lands on the clock edge that samples the stimulus. The request level and read data are combinational from those registers, so they are due in the cycle after the stimulus. The error pulse comes from its own flop and is also due one cycle after the offending write. The bench drives each stimulus shortly after a rising edge and updates its reference model on the following edge. It compares the level, the error output and the selected read data a short time after that same edge, so each result is taken exactly one cycle after its cause.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_LVL = 15;
  localparam int VEC_W   = NUM_LVL + 1;
  localparam int LVL_W   = $clog2(VEC_W);
  localparam int DATA_W  = 32;

  // bits 15:1 usable as levels; mask omits the top (non-maskable) level
  localparam logic [VEC_W-1:0] LVL_KEEP  = {{NUM_LVL{1'b1}}, 1'b0};
  localparam logic [VEC_W-1:0] MASK_KEEP = {1'b0, {(NUM_LVL-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_FORCE = 2'd2,
    SEL_TEST  = 2'd3
  } reg_sel_e;

  // highest set bit among levels, 0 if none
  function automatic logic [LVL_W-1:0] top_level(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < VEC_W; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] level_bit(input logic [LVL_W-1:0] l);
    return (VEC_W'(1) << l) & LVL_KEEP;
  endfunction

  function automatic logic has_illegal(input logic [DATA_W-1:0] d,
                                       input logic [VEC_W-1:0] keep);
    return |(d & ~{{(DATA_W-VEC_W){1'b0}}, keep});
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] set_vec,
  input  logic [VEC_W-1:0] clr_vec,
  output logic [VEC_W-1:0] pend_q
);
  logic [VEC_W-1:0] set_eff;
  logic [VEC_W-1:0] clr_only;

  assign set_eff  = set_vec & LVL_KEEP;
  assign clr_only = clr_vec & ~set_eff & LVL_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= ((pend_q & ~clr_vec) | set_eff) & LVL_KEEP;
  end

  // R10: a pulse always lands in pending
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((pend_q & $past(set_eff)) == $past(set_eff)));

  // R5/R8: cleared bits without a competing pulse are gone next cycle
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_only) |=> ((pend_q & $past(clr_only)) == '0));
endmodule

// File: rtl/irq_force_reg.sv
module irq_force_reg
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] load_val,
  input  logic [VEC_W-1:0] ack_clr,
  output logic [VEC_W-1:0] force_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    force_q <= '0;
    else if (load) force_q <= load_val & LVL_KEEP;
    else           force_q <= force_q & ~ack_clr;
  end

  // R8: an acknowledged force bit is dropped
  p_ack_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_clr) && !load) |=> ((force_q & $past(ack_clr)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] pend_vec,
  input  logic [VEC_W-1:0] force_vec,
  input  logic [VEC_W-1:0] mask_vec,
  input  logic             test_en,
  output logic [VEC_W-1:0] active_vec,
  output logic [LVL_W-1:0] level
);
  logic [VEC_W-1:0] src_vec;

  assign src_vec    = pend_vec | (test_en ? force_vec : '0);
  assign active_vec = src_vec & ~mask_vec & LVL_KEEP;
  assign level      = top_level(active_vec);

  // R2: a reported level has an unmasked source behind it
  p_level_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> (src_vec[level] && !mask_vec[level]));

  // R3: the top level cannot be hidden by the mask
  p_top_unmaskable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[NUM_LVL] |-> (level == LVL_W'(NUM_LVL)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int OVR_LVL  = 7,
  parameter int TEST_BIT = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  src_pulse,
  input  logic              ovr_a,
  input  logic              ovr_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [LVL_W-1:0]  irq_level,
  output logic              par_err
);
  localparam logic [VEC_W-1:0] OVR_BIT = VEC_W'(1) << OVR_LVL;

  reg_sel_e         wsel, rsel;
  logic             wr_mask, wr_clr, wr_frc, wr_test;
  logic [VEC_W-1:0] mask_q, pend_q, force_q, active_vec;
  logic             test_q;
  logic [VEC_W-1:0] ack_bit, ack_frc_clr, ack_pend_clr;
  logic             ack_force_hit;
  logic [VEC_W-1:0] set_vec, clr_vec;
  logic             mask_bad, clr_bad;

  assign wsel    = reg_sel_e'(wr_sel);
  assign rsel    = reg_sel_e'(rd_sel);
  assign wr_mask = wr_en && (wsel == SEL_MASK);
  assign wr_clr  = wr_en && (wsel == SEL_PEND);
  assign wr_frc  = wr_en && (wsel == SEL_FORCE) && test_q;
  assign wr_test = wr_en && (wsel == SEL_TEST);

  // acknowledge routing: force bit first when test mode owns it
  assign ack_bit       = ack_valid ? level_bit(ack_level) : '0;
  assign ack_force_hit = test_q && |(force_q & ack_bit);
  assign ack_frc_clr   = ack_force_hit ? ack_bit : '0;
  assign ack_pend_clr  = ack_force_hit ? '0 : ack_bit;

  assign set_vec = (src_pulse & LVL_KEEP) | ((ovr_a || ovr_b) ? OVR_BIT : '0);
  assign clr_vec = (wr_clr ? wr_data[VEC_W-1:0] : '0) | ack_pend_clr;

  assign mask_bad = wr_mask && has_illegal(wr_data, MASK_KEEP);
  assign clr_bad  = wr_clr  && has_illegal(wr_data, LVL_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      test_q  <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wr_data[VEC_W-1:0] & MASK_KEEP;
      if (wr_test) test_q <= wr_data[TEST_BIT];
      par_err <= mask_bad || clr_bad;
    end
  end

  irq_pend_reg u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  irq_force_reg u_force (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_frc),
    .load_val (wr_data[VEC_W-1:0]),
    .ack_clr  (ack_frc_clr),
    .force_q  (force_q)
  );

  irq_prio_enc u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_vec   (pend_q),
    .force_vec  (force_q),
    .mask_vec   (mask_q),
    .test_en    (test_q),
    .active_vec (active_vec),
    .level      (irq_level)
  );

  always_comb begin
    rd_data = '0;
    unique case (rsel)
      SEL_MASK:  rd_data[VEC_W-1:0] = mask_q;
      SEL_PEND:  rd_data[VEC_W-1:0] = pend_q;
      SEL_FORCE: rd_data[VEC_W-1:0] = force_q;
      SEL_TEST:  rd_data[TEST_BIT]  = test_q;
      default:   rd_data = '0;
    endcase
  end

  // R4: illegal mask bits raise the error pulse next cycle
  p_err_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && |(wr_data & ~DATA_W'(MASK_KEEP))) |=> par_err);

  // R6: force holds when written outside test mode
  p_force_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_FORCE) && !test_q && !ack_valid) |=> $stable(force_q));

  // R9: overrun from either channel lands on its level
  p_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_a || ovr_b) |=> pend_q[OVR_LVL]);

  // R11: bit 0 never becomes active
  p_bit0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_vec[0]);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] src;
  logic        ovr_a, ovr_b, wr_en, ack_valid;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data;
  logic [3:0]  ack_level;
  logic [31:0] rd_data;
  logic [3:0]  irq_level;
  logic        par_err;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src), .ovr_a(ovr_a), .ovr_b(ovr_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .par_err(par_err)
  );

  // reference state
  logic [15:0] m_pend, m_mask, m_frc;
  logic        m_test, m_err;
  int          checks = 0;
  int          errors = 0;
  string       tag = "R1";
  bit          done = 0;

  function automatic int exp_level();
    int lv = 0;
    logic [15:0] act;
    act = (m_pend | (m_test ? m_frc : 16'h0)) & ~m_mask;
    for (int k = 15; k >= 1; k--)
      if (act[k] && lv == 0) lv = k;
    return lv;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return {16'h0, m_mask};
      2'd1:    return {16'h0, m_pend};
      2'd2:    return {16'h0, m_frc};
      default: return {12'h0, m_test, 19'h0};
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [15:0] abit, np, nf, nm;
    logic        hit, ne, nt;
    abit = ack_valid ? (16'h1 << ack_level) : 16'h0;
    abit[0] = 1'b0;
    hit = m_test && ((m_frc & abit) != 16'h0);
    np = m_pend;
    nf = m_frc;
    nm = m_mask;
    nt = m_test;
    if (hit) nf = nf & ~abit;
    else     np = np & ~abit;
    if (wr_en && wr_sel == 2'd1) np = np & ~wr_data[15:0];
    if (wr_en && wr_sel == 2'd2 && m_test) nf = wr_data[15:0] & 16'hFFFE;
    if (wr_en && wr_sel == 2'd0) nm = wr_data[15:0] & 16'h7FFE;
    if (wr_en && wr_sel == 2'd3) nt = wr_data[19];
    np = np | src;
    if (ovr_a || ovr_b) np[7] = 1'b1;
    np[0] = 1'b0;
    ne = wr_en && ((wr_sel == 2'd0 && (wr_data & ~32'h0000_7FFE) != 0) ||
                   (wr_sel == 2'd1 && (wr_data & ~32'h0000_FFFE) != 0));
    @(posedge clk);
    #2;
    m_pend = np; m_frc = nf; m_mask = nm; m_test = nt; m_err = ne;
    check("irq_level", {28'h0, irq_level}, 32'(exp_level()));
    check("par_err", {31'h0, par_err}, {31'h0, m_err});
    check("rd_data", rd_data, exp_rd(rd_sel));
    src = '0; ovr_a = 0; ovr_b = 0; wr_en = 0; ack_valid = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask
  task automatic pulse(input logic [15:0] v);
    src = v; step();
  endtask
  task automatic ack(input logic [3:0] l);
    ack_valid = 1; ack_level = l; step();
  endtask
  task automatic look(input logic [1:0] s);
    rd_sel = s; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src = '0; ovr_a = 0; ovr_b = 0; wr_en = 0; wr_sel = 0;
    wr_data = '0; rd_sel = 0; ack_valid = 0; ack_level = 0;
    m_pend = 0; m_mask = 0; m_frc = 0; m_test = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset values on every read select
    tag = "R1";
    for (int s = 0; s < 4; s++) look(2'(s));
    // R2: priority and acknowledge order
    tag = "R2";
    rd_sel = 2'd1;
    pulse(16'h0208);
    ack(4'd9);
    ack(4'd3);
    pulse(16'h4002); pulse(16'h0100);
    ack(4'd14); ack(4'd8); ack(4'd1);
    // R3: mask keeps 14:1, level 15 unmaskable
    tag = "R3";
    rd_sel = 2'd0;
    wr(2'd0, 32'h0000_7FFE);
    pulse(16'h8020);
    ack(4'd15);
    wr(2'd0, 32'h0000_0000);
    // R4: illegal mask bits
    tag = "R4";
    wr(2'd0, 32'h0000_8000);
    look(2'd0);
    wr(2'd0, 32'h0000_0001);
    wr(2'd0, 32'h8000_0010);
    wr(2'd0, 32'h0000_0000);
    // R5: clear register
    tag = "R5";
    rd_sel = 2'd1;
    pulse(16'h0C30);
    wr(2'd1, 32'h0000_0420);
    wr(2'd1, 32'h0001_0010);
    wr(2'd1, 32'h0000_0801);
    // R6: force locked outside test mode
    tag = "R6";
    rd_sel = 2'd2;
    wr(2'd2, 32'h0000_0110);
    wr(2'd3, 32'h0008_0000);
    wr(2'd2, 32'h0000_0111);
    look(2'd3);
    // R7: force matters only in test mode
    tag = "R7";
    wr(2'd3, 32'h0000_0000);
    wr(2'd3, 32'h0008_0000);
    // R8: acknowledge prefers force bit in test mode
    tag = "R8";
    rd_sel = 2'd2;
    pulse(16'h0100);
    ack(4'd8);
    look(2'd1);
    ack(4'd8);
    ack(4'd4);
    look(2'd2);
    wr(2'd3, 32'h0000_0000);
    pulse(16'h0010);
    ack(4'd4);
    // R9: overrun routing
    tag = "R9";
    rd_sel = 2'd1;
    ovr_a = 1; step();
    ack(4'd7);
    ovr_b = 1; step();
    ack(4'd7);
    // R10: set beats clear and acknowledge
    tag = "R10";
    src = 16'h0010; wr(2'd1, 32'h0000_0010);
    src = 16'h0010; ack(4'd4);
    ovr_a = 1; ack(4'd7);
    wr(2'd1, 32'h0000_0090);
    // R11: bit 0 ignored
    tag = "R11";
    pulse(16'h0001);
    wr(2'd0, 32'h0000_0000);
    look(2'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule